// File: doc/BRIEF.md
# Signature Accelerator Control Front-End

This block is the register and sequencing front-end of a signature accelerator. Software reaches it through a plain memory-mapped port: a write strobe with address and data, and a read data bus that shows the addressed register without any wait. The block holds the job configuration, runs the job handshake that takes one operation from input loading through computation to result readout, and drives single-cycle start strobes toward an external curve-arithmetic core and a small hash engine. The arithmetic itself is outside the block.

A job runs as follows. Software issues start, which moves the job from idle to loading. After the operands are in place, load-done moves the job to busy and strobes the core. When the core reports completion, the block latches its one-bit result, sets the calculation-done interrupt and moves to the get state. After reading the result, software issues get-done and the job returns to idle. Software can read the job state at any time. Two interrupt sources, calculation-done and hash-release, each have a sticky raw bit, an enable bit, a masked status bit and a write-one clear.

All ports are plain control and status pins. The bus has no back-pressure: every write takes effect at the clock edge where it is presented. Core and hash completions are one-cycle pulses that the block accepts without any handshake.

Top module: `sig_ctrl_front`

## Requirements
- R1: After reset the job state is 0, every register and raw interrupt bit reads 0, `irq` is 0, and the version register at 0xFC reads 35684752.
- R2: The configuration register at 0x4 holds work mode (bit 0), curve select (bit 1), software nonce (bit 2) and software hash input (bit 3). It reads back as written and drives `cfg_gen`, `cfg_wide`, `cfg_nonce_sw` and `cfg_hash_sw`.
- R3: The command register at 0x1C acts on bit 0 = start, bit 1 = load-done and bit 2 = get-done, and always reads 0. The job state appears in bits [1:0] at 0x20 with the encoding 0 idle, 1 load, 2 get, 3 busy.
- R4: Start in idle moves the job to load. Load-done in load moves it to busy and raises `core_start` for exactly one cycle, in the cycle after the write. A `core_done` pulse in busy moves it to get. Get-done in get returns it to idle.
- R5: A command given in any other state, and a `core_done` pulse outside busy, changes neither the job state nor the interrupt bits.
- R6: The result register at 0x24 bit 0 takes the value of `core_result` at the `core_done` pulse that ends a busy phase.
- R7: Raw interrupt bits at 0xC are bit 0 calculation-done (set when busy ends) and bit 1 hash-release (set by `hash_release`). Each stays set until a write of 1 to the same bit at 0x18.
- R8: The enable register at 0x14 masks the raw bits. The status register at 0x10 reads raw AND enable, and `irq` is the OR of the status bits.
- R9: When a clear write and a hardware set hit the same raw bit in the same cycle, the bit ends up set.
- R10: The hash mode field at 0x200 bits [2:0] is valid at 1 or 2. A write of bit 0 at 0x210 (first block) or at 0x214 (continue), made while the mode is valid and the engine is idle, strobes `hash_first` or `hash_next` for one cycle and sets the busy bit at 0x218. A `hash_done` pulse clears busy.
- R11: With an invalid hash mode, or while the engine is busy, a first or continue command strobes nothing and leaves busy unchanged.
- R12: Bit 0 at 0x8 is a read/write clock-gate force bit that drives `cg_force`. The 28-bit version register at 0xFC is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| cfg_gen | output | 1 | Work mode: 1 generate, 0 verify |
| cfg_wide | output | 1 | Curve select: 1 for 256-bit, 0 for 192-bit |
| cfg_nonce_sw | output | 1 | Nonce comes from software |
| cfg_hash_sw | output | 1 | Hash input comes from software |
| cg_force | output | 1 | Clock-gate force-on |
| core_start | output | 1 | One-cycle start to the arithmetic core |
| core_done | input | 1 | Completion pulse from the core |
| core_result | input | 1 | Core result bit, valid with core_done |
| hash_mode | output | 3 | Hash engine mode |
| hash_first | output | 1 | One-cycle first-block start to the hash engine |
| hash_next | output | 1 | One-cycle continue start to the hash engine |
| hash_done | input | 1 | Hash engine completion pulse |
| hash_release | input | 1 | Hash-release event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The case hardest to reach from the ports is a software clear that lands in the same cycle as the hardware event that sets the same raw bit. The bench gets there with a write task that asserts `core_done` (or `hash_release`) during the write cycle aimed at the clear register. It first parks the job in busy so that the completion is honoured. The commands that the current state should ignore are each issued from the wrong state, and the state register is read back before the next command.

// File: rtl/sigfe_pkg.sv
package sigfe_pkg;
  localparam int ADDR_W = 12;
  localparam int NIRQ   = 2;
  localparam int VER_W  = 28;
  localparam int HMW    = 3;

  typedef enum logic [1:0] {
    JOB_IDLE = 2'd0,
    JOB_LOAD = 2'd1,
    JOB_GET  = 2'd2,
    JOB_BUSY = 2'd3
  } job_st_t;

  localparam logic [ADDR_W-1:0] A_CFG   = 12'h004;
  localparam logic [ADDR_W-1:0] A_CGATE = 12'h008;
  localparam logic [ADDR_W-1:0] A_RAW   = 12'h00C;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h010;
  localparam logic [ADDR_W-1:0] A_ENA   = 12'h014;
  localparam logic [ADDR_W-1:0] A_CLR   = 12'h018;
  localparam logic [ADDR_W-1:0] A_CMD   = 12'h01C;
  localparam logic [ADDR_W-1:0] A_STATE = 12'h020;
  localparam logic [ADDR_W-1:0] A_RES   = 12'h024;
  localparam logic [ADDR_W-1:0] A_VER   = 12'h0FC;
  localparam logic [ADDR_W-1:0] A_HMODE = 12'h200;
  localparam logic [ADDR_W-1:0] A_HGO   = 12'h210;
  localparam logic [ADDR_W-1:0] A_HNXT  = 12'h214;
  localparam logic [ADDR_W-1:0] A_HBUSY = 12'h218;

  localparam logic [VER_W-1:0] VER_RST = 28'd35684752;
  localparam logic [HMW-1:0]   HM_224  = 3'd1;
  localparam logic [HMW-1:0]   HM_256  = 3'd2;
endpackage

// File: rtl/sigfe_job_fsm.sv
module sigfe_job_fsm
  import sigfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    go_cmd,
  input  logic    loaded_cmd,
  input  logic    taken_cmd,
  input  logic    core_done,
  output job_st_t state,
  output logic    core_start,
  output logic    finish
);
  // Completion is honoured only while the core is working.
  assign finish = (state == JOB_BUSY) && core_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= JOB_IDLE;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      case (state)
        JOB_IDLE: if (go_cmd) state <= JOB_LOAD;
        JOB_LOAD: if (loaded_cmd) begin
          state      <= JOB_BUSY;
          core_start <= 1'b1;
        end
        JOB_BUSY: if (core_done) state <= JOB_GET;
        JOB_GET:  if (taken_cmd) state <= JOB_IDLE;
        default:  state <= JOB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sigfe_irq.sv
module sigfe_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic [N-1:0] sw_clr,
  input  logic [N-1:0] ena,
  output logic [N-1:0] raw,
  output logic [N-1:0] masked,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)         raw[i] <= 1'b0;
      else if (hw_set[i]) raw[i] <= 1'b1;   // set beats a clear in the same cycle
      else if (sw_clr[i]) raw[i] <= 1'b0;
    end
  end

  assign masked = raw & ena;
  assign irq    = |masked;
endmodule

// File: rtl/sigfe_hash_ctl.sv
module sigfe_hash_ctl
  import sigfe_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HMW-1:0] mode,
  input  logic           first_cmd,
  input  logic           next_cmd,
  input  logic           done,
  output logic           first_go,
  output logic           next_go,
  output logic           busy
);
  logic mode_ok, can_go;

  assign mode_ok = (mode == HM_224) || (mode == HM_256);
  assign can_go  = mode_ok && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_go <= 1'b0;
      next_go  <= 1'b0;
      busy     <= 1'b0;
    end else begin
      first_go <= first_cmd && can_go;
      next_go  <= next_cmd && !first_cmd && can_go;
      if (can_go && (first_cmd || next_cmd)) busy <= 1'b1;
      else if (done)                         busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sig_ctrl_front.sv
module sig_ctrl_front
  import sigfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              cfg_gen,
  output logic              cfg_wide,
  output logic              cfg_nonce_sw,
  output logic              cfg_hash_sw,
  output logic              cg_force,
  output logic              core_start,
  input  logic              core_done,
  input  logic              core_result,
  output logic [HMW-1:0]    hash_mode,
  output logic              hash_first,
  output logic              hash_next,
  input  logic              hash_done,
  input  logic              hash_release,
  output logic              irq
);
  logic [3:0]      cfg_q;
  logic            cg_q;
  logic [NIRQ-1:0] ena_q;
  logic [HMW-1:0]  hmode_q;
  logic [VER_W-1:0] ver_q;
  logic            res_q;
  job_st_t         state_q;
  logic            job_finish;
  logic [NIRQ-1:0] irq_set, irq_clr, raw_q, stat_q;
  logic            h_busy;
  logic            wr_cmd, wr_clr, wr_hgo, wr_hnxt;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[31:VER_W];

  assign wr_cmd  = wr_en && (addr == A_CMD);
  assign wr_clr  = wr_en && (addr == A_CLR);
  assign wr_hgo  = wr_en && (addr == A_HGO);
  assign wr_hnxt = wr_en && (addr == A_HNXT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cg_q    <= 1'b0;
      ena_q   <= '0;
      hmode_q <= '0;
      ver_q   <= VER_RST;
      res_q   <= 1'b0;
    end else begin
      if (wr_en && addr == A_CFG)   cfg_q   <= wdata[3:0];
      if (wr_en && addr == A_CGATE) cg_q    <= wdata[0];
      if (wr_en && addr == A_ENA)   ena_q   <= wdata[NIRQ-1:0];
      if (wr_en && addr == A_HMODE) hmode_q <= wdata[HMW-1:0];
      if (wr_en && addr == A_VER)   ver_q   <= wdata[VER_W-1:0];
      if (job_finish)               res_q   <= core_result;
    end
  end

  sigfe_job_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_cmd     (wr_cmd && wdata[0]),
    .loaded_cmd (wr_cmd && wdata[1]),
    .taken_cmd  (wr_cmd && wdata[2]),
    .core_done  (core_done),
    .state      (state_q),
    .core_start (core_start),
    .finish     (job_finish)
  );

  assign irq_set = {hash_release, job_finish};
  assign irq_clr = wr_clr ? wdata[NIRQ-1:0] : '0;

  sigfe_irq #(.N(NIRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_set (irq_set),
    .sw_clr (irq_clr),
    .ena    (ena_q),
    .raw    (raw_q),
    .masked (stat_q),
    .irq    (irq)
  );

  sigfe_hash_ctl u_hash (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (hmode_q),
    .first_cmd (wr_hgo && wdata[0]),
    .next_cmd  (wr_hnxt && wdata[0]),
    .done      (hash_done),
    .first_go  (hash_first),
    .next_go   (hash_next),
    .busy      (h_busy)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_CFG:   rdata[3:0]        = cfg_q;
      A_CGATE: rdata[0]          = cg_q;
      A_RAW:   rdata[NIRQ-1:0]   = raw_q;
      A_STAT:  rdata[NIRQ-1:0]   = stat_q;
      A_ENA:   rdata[NIRQ-1:0]   = ena_q;
      A_STATE: rdata[1:0]        = state_q;
      A_RES:   rdata[0]          = res_q;
      A_VER:   rdata[VER_W-1:0]  = ver_q;
      A_HMODE: rdata[HMW-1:0]    = hmode_q;
      A_HBUSY: rdata[0]          = h_busy;
      default: rdata = '0;
    endcase
  end

  assign cfg_gen      = cfg_q[0];
  assign cfg_wide     = cfg_q[1];
  assign cfg_nonce_sw = cfg_q[2];
  assign cfg_hash_sw  = cfg_q[3];
  assign cg_force     = cg_q;
  assign hash_mode    = hmode_q;
endmodule

// File: rtl/sigfe_chk.sv
module sigfe_chk
  import sigfe_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input job_st_t         state,
  input logic            core_start,
  input logic [NIRQ-1:0] raw,
  input logic [NIRQ-1:0] irq_set,
  input logic            hash_first,
  input logic            hash_next,
  input logic [HMW-1:0]  hash_mode,
  input logic            hash_busy
);
  // R4
  core_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  // R4
  core_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> state == JOB_BUSY);

  // R5
  load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == JOB_LOAD && $past(state) != JOB_LOAD) |-> $past(state) == JOB_IDLE);

  // R7
  calc_raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw[0]) |-> $past(state) == JOB_BUSY);

  // R9
  calc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set[0] |=> raw[0]);

  // R9
  rel_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set[1] |=> raw[1]);

  // R11
  hash_mode_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hash_first || hash_next) |-> ($past(hash_mode) == HM_224 || $past(hash_mode) == HM_256));

  // R10
  hash_busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hash_busy) |-> (hash_first || hash_next));

  // R10
  hash_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hash_first, hash_next}));
endmodule

bind sig_ctrl_front sigfe_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state_q),
  .core_start (core_start),
  .raw        (raw_q),
  .irq_set    (irq_set),
  .hash_first (hash_first),
  .hash_next  (hash_next),
  .hash_mode  (hash_mode),
  .hash_busy  (h_busy)
);

// File: tb/sim_sig_ctrl_front.sv
module sim_sig_ctrl_front;
  import sigfe_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic cfg_gen, cfg_wide, cfg_nonce_sw, cfg_hash_sw, cg_force;
  logic core_start, hash_first, hash_next, irq;
  logic core_done = 1'b0, core_result = 1'b0;
  logic [HMW-1:0] hash_mode;
  logic hash_done = 1'b0, hash_release = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [31:0]       e;
    string             tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  sig_ctrl_front u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cfg_gen(cfg_gen), .cfg_wide(cfg_wide),
    .cfg_nonce_sw(cfg_nonce_sw), .cfg_hash_sw(cfg_hash_sw), .cg_force(cg_force),
    .core_start(core_start), .core_done(core_done), .core_result(core_result),
    .hash_mode(hash_mode), .hash_first(hash_first), .hash_next(hash_next),
    .hash_done(hash_done), .hash_release(hash_release), .irq(irq)
  );

  // Monitor: compares each queued read expectation at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      total++;
      if (rdata !== it.e) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.e);
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    addr = a;
    sb.push_back('{a: a, e: e, tag: tag});
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  // Write that coincides with a hardware event pulse in the same cycle.
  task automatic wr_evt(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input bit cdone, input bit rel, input bit res);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    core_done = cdone; core_result = res; hash_release = rel;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0; core_done = 1'b0; hash_release = 1'b0;
  endtask

  // Core model: completion after a programmable number of cycles.
  task automatic core_fire(input int dly, input bit res);
    repeat (dly) @(posedge clk);
    #1; core_done = 1'b1; core_result = res;
    @(posedge clk); #1; core_done = 1'b0; core_result = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(posedge clk); #1; s = 1'b1;
    @(posedge clk); #1; s = 1'b0;
  endtask

  task automatic pin(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_STATE, 32'd0, "R1 state");
    rd(A_CFG, 32'd0, "R1 cfg");
    rd(A_RAW, 32'd0, "R1 raw");
    rd(A_VER, 32'd35684752, "R1 version");
    pin("R1 irq", irq, 1'b0);

    // R2 configuration
    wr(A_CFG, 32'hFFFF_FFF5);
    rd(A_CFG, 32'h5, "R2 cfg readback");
    pin("R2 cfg_gen", cfg_gen, 1'b1);
    pin("R2 cfg_wide", cfg_wide, 1'b0);
    pin("R2 cfg_nonce_sw", cfg_nonce_sw, 1'b1);
    pin("R2 cfg_hash_sw", cfg_hash_sw, 1'b0);
    wr(A_CFG, 32'hA);
    pin("R2 cfg_wide set", cfg_wide, 1'b1);
    pin("R2 cfg_hash_sw set", cfg_hash_sw, 1'b1);

    // R12 clock gate and version
    wr(A_CGATE, 32'h1);
    pin("R12 cg_force", cg_force, 1'b1);
    rd(A_CGATE, 32'h1, "R12 cgate readback");
    wr(A_VER, 32'hF123_4567);
    rd(A_VER, 32'h0123_4567, "R12 version write");

    // R5 ignored commands from idle, stray core done
    wr(A_CMD, 32'h6);
    rd(A_STATE, 32'd0, "R5 load/get ignored in idle");
    core_fire(0, 1'b1);
    rd(A_RAW, 32'd0, "R5 core_done ignored in idle");
    rd(A_STATE, 32'd0, "R5 state after stray done");

    // R3 R4 first job
    wr(A_CMD, 32'h1);
    rd(A_STATE, 32'd1, "R4 start to load");
    rd(A_CMD, 32'd0, "R3 command reads zero");
    wr(A_CMD, 32'h4);
    rd(A_STATE, 32'd1, "R5 get-done ignored in load");
    wr(A_CMD, 32'h1);
    rd(A_STATE, 32'd1, "R5 start ignored in load");
    wr(A_CMD, 32'h2);
    pin("R4 core_start pulse", core_start, 1'b1);
    @(posedge clk); #1;
    pin("R4 core_start single cycle", core_start, 1'b0);
    rd(A_STATE, 32'd3, "R3 busy encoding");
    wr(A_CMD, 32'h4);
    rd(A_STATE, 32'd3, "R5 get-done ignored in busy");
    core_fire(5, 1'b1);
    rd(A_STATE, 32'd2, "R4 done to get");
    rd(A_RES, 32'd1, "R6 result one");
    rd(A_RAW, 32'd1, "R7 calc raw set");
    pin("R8 irq masked", irq, 1'b0);
    rd(A_STAT, 32'd0, "R8 status masked");
    wr(A_ENA, 32'h3);
    pin("R8 irq on", irq, 1'b1);
    rd(A_STAT, 32'd1, "R8 status");
    core_fire(0, 1'b0);
    rd(A_RES, 32'd1, "R5 done in get ignored");
    wr(A_CLR, 32'h1);
    rd(A_RAW, 32'd0, "R7 clear");
    pin("R8 irq off", irq, 1'b0);
    wr(A_CMD, 32'h4);
    rd(A_STATE, 32'd0, "R4 get to idle");

    // R9 set beats clear, second job with result 0
    wr(A_CMD, 32'h1);
    wr(A_CMD, 32'h2);
    wr_evt(A_CLR, 32'h1, 1'b1, 1'b0, 1'b0);
    rd(A_RAW, 32'd1, "R9 calc set wins");
    rd(A_RES, 32'd0, "R6 result zero");
    rd(A_STATE, 32'd2, "R4 second job get");
    wr(A_CMD, 32'h4);

    // R7 R9 hash-release source
    pulse(hash_release);
    rd(A_RAW, 32'd3, "R7 release raw");
    wr(A_CLR, 32'h2);
    rd(A_RAW, 32'd1, "R7 release cleared only");
    wr_evt(A_CLR, 32'h3, 1'b0, 1'b1, 1'b0);
    rd(A_RAW, 32'd2, "R9 release set wins");
    wr(A_ENA, 32'h0);
    pin("R8 irq disabled", irq, 1'b0);
    rd(A_RAW, 32'd2, "R8 raw kept while disabled");

    // R10 R11 hash engine
    wr(A_HMODE, 32'h5);
    wr(A_HGO, 32'h1);
    pin("R11 no start on invalid mode", hash_first, 1'b0);
    rd(A_HBUSY, 32'd0, "R11 busy stays 0");
    wr(A_HMODE, 32'h2);
    rd(A_HMODE, 32'h2, "R10 mode readback");
    pin("R10 hash_mode pin", hash_mode == 3'd2, 1'b1);
    wr(A_HGO, 32'h1);
    pin("R10 first strobe", hash_first, 1'b1);
    rd(A_HBUSY, 32'd1, "R10 busy set");
    pin("R10 first single cycle", hash_first, 1'b0);
    wr(A_HNXT, 32'h1);
    pin("R11 no continue while busy", hash_next, 1'b0);
    pulse(hash_done);
    rd(A_HBUSY, 32'd0, "R10 done clears busy");
    wr(A_HMODE, 32'h1);
    wr(A_HNXT, 32'h1);
    pin("R10 continue strobe", hash_next, 1'b1);
    pin("R10 no first on continue", hash_first, 1'b0);
    rd(A_HBUSY, 32'd1, "R10 busy after continue");
    pulse(hash_done);

    // R1 reset again
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(A_RAW, 32'd0, "R1 raw after reset");
    rd(A_VER, 32'd35684752, "R1 version after reset");
    rd(A_HMODE, 32'd0, "R1 hash mode after reset");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule